// File: doc/BRIEF.md
# Two-Stage Programmable Clock Divider

This block turns one oscillator clock into three slower timing strobes for a radio transceiver: a bit-rate strobe, a bit-synchronization strobe and a modulator strobe. A shared prescaler divides the oscillator by a programmable integer K. A single post-divider counter, advanced by the prescaler, then gives each strobe its own power-of-two ratio 2^S. Every strobe is a one-cycle clock-enable pulse in the oscillator domain. Each strobe also has a square-wave companion that flips on every pulse.

The ratios come from two 8-bit control words, each written through its own strobe. The block pulls the divider fields out of these words. Any write restarts both stages from a known phase, so a new ratio takes effect cleanly. In normal use the synchronization strobe is set 16 times faster than the bit-rate strobe, and the modulator strobe 8 or 16 times faster. The block does not enforce these relations.

The control pins are plain level and strobe signals with no handshake. A write is accepted in every cycle in which its strobe is high.

Top module: `osc_clk_divider`

## Requirements
- R1: Synchronous reset clears both control words to zero and clears all three square-wave outputs. With zeroed words (K treated as 1, every S equal to 0), all three strobes are high in the first cycle after reset.
- R2: Field layout. K is word B bits [5:0]. The modulator S is word A bits [6:4]. The synchronization S is word A bits [3:1]. The bit-rate S is {word A bit 0, word B bits [7:6]}, with word A bit 0 as the most significant bit.
- R3: A K value of 0 behaves exactly like K = 1, so the prescaler never stalls.
- R4: A write to either word restarts the prescaler and the post-divider on the clock edge that samples the write. The first pulse of each strobe then appears in cycle K·2^S − 1, counting the cycle right after that edge as cycle 0.
- R5: Between writes, consecutive pulses on each strobe are exactly K·2^S cycles apart.
- R6: When K·2^S is greater than 1, each pulse is exactly one cycle wide.
- R7: The strobes are phase-aligned. Whenever a strobe with the larger S pulses, every strobe with an equal or smaller S pulses in the same cycle.
- R8: Each square-wave output inverts on the clock edge that ends a cycle in which its strobe is high, and holds its value otherwise. Writes do not clear it; only reset does.
- R9: A write to one word leaves the other word unchanged. The two words may also be written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_a_wr | input | 1 | Write strobe for word A |
| ctl_a_data | input | 8 | Word A: modulator, synchronization and bit-rate MSB selects |
| ctl_b_wr | input | 1 | Write strobe for word B |
| ctl_b_data | input | 8 | Word B: prescaler ratio and bit-rate select low bits |
| rate_en | output | 1 | Bit-rate strobe |
| sync_en | output | 1 | Bit-synchronization strobe |
| mod_en | output | 1 | Modulator strobe |
| rate_clk | output | 1 | Bit-rate square wave |
| sync_clk | output | 1 | Synchronization square wave |
| mod_clk | output | 1 | Modulator square wave |

## Verification
A wrong prescaler count or a corrupted post-divider counter shows up as the wrong gap between pulses. It can also move the first pulse after a write away from cycle K·2^S − 1. The error appears within one full output period, which is at most 63·128 cycles. A mis-decoded field shifts only the strobe that uses it, so each strobe's interval is measured separately. A lost phase relation shows up in the first cycle where a slower strobe pulses without the faster ones. A toggle fault shows up one edge after a pulse.

// File: rtl/ocd_pkg.sv
package ocd_pkg;
  localparam int REG_W  = 8;
  localparam int K_W    = 6;
  localparam int S_W    = 3;
  localparam int N_OUT  = 3;
  localparam int CNT_W  = (1 << S_W) - 1;

  localparam int IDX_RATE = 0;
  localparam int IDX_SYNC = 1;
  localparam int IDX_MOD  = 2;

  typedef struct packed {
    logic [K_W-1:0]            k;
    logic [N_OUT-1:0][S_W-1:0] sel;
  } div_cfg_t;

  function automatic div_cfg_t decode_words(input logic [REG_W-1:0] wa,
                                            input logic [REG_W-1:0] wb);
    div_cfg_t c;
    c.k             = wb[5:0];
    c.sel[IDX_MOD]  = wa[6:4];
    c.sel[IDX_SYNC] = wa[3:1];
    c.sel[IDX_RATE] = {wa[0], wb[7:6]};
    return c;
  endfunction
endpackage

// File: rtl/ocd_cfg_regs.sv
module ocd_cfg_regs
  import ocd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_a,
  input  logic [REG_W-1:0] data_a,
  input  logic             wr_b,
  input  logic [REG_W-1:0] data_b,
  output div_cfg_t         cfg,
  output logic             restart
);
  logic [REG_W-1:0] word_a, word_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_a <= '0;
      word_b <= '0;
    end else begin
      if (wr_a) word_a <= data_a;
      if (wr_b) word_b <= data_b;
    end
  end

  assign cfg     = decode_words(word_a, word_b);
  // restart is applied on the same edge that loads the new word
  assign restart = wr_a | wr_b;
endmodule

// File: rtl/ocd_prescaler.sv
module ocd_prescaler #(
  parameter int K_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic [K_W-1:0] k_raw,
  output logic [K_W-1:0] k_eff,
  output logic           tick
);
  logic [K_W-1:0] cnt;
  logic [K_W-1:0] last;

  assign k_eff = (k_raw == '0) ? K_W'(1) : k_raw;
  assign last  = k_eff - K_W'(1);
  assign tick  = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (cnt >= last) cnt <= '0;
    else                  cnt <= cnt + K_W'(1);
  end
endmodule

// File: rtl/ocd_postdiv.sv
module ocd_postdiv #(
  parameter int S_W   = 3,
  parameter int N_OUT = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      restart,
  input  logic                      tick,
  input  logic [N_OUT-1:0][S_W-1:0] sel,
  output logic [N_OUT-1:0]          en,
  output logic [N_OUT-1:0]          sq
);
  localparam int CNT_W = (1 << S_W) - 1;

  logic [CNT_W-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst || restart) pc <= '0;
    else if (tick)      pc <= pc + CNT_W'(1);
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic [CNT_W-1:0] mask;
    always_comb begin
      for (int b = 0; b < CNT_W; b++) mask[b] = (b < int'(sel[i]));
    end
    assign en[i] = tick && ((pc & mask) == mask);

    always_ff @(posedge clk) begin
      if (rst)        sq[i] <= 1'b0;
      else if (en[i]) sq[i] <= ~sq[i];
    end
  end
endmodule

// File: rtl/osc_clk_divider.sv
module osc_clk_divider
  import ocd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_a_wr,
  input  logic [7:0] ctl_a_data,
  input  logic       ctl_b_wr,
  input  logic [7:0] ctl_b_data,
  output logic       rate_en,
  output logic       sync_en,
  output logic       mod_en,
  output logic       rate_clk,
  output logic       sync_clk,
  output logic       mod_clk
);
  div_cfg_t         cfg;
  logic             restart;
  logic             tick;
  logic [K_W-1:0]   k_eff;
  logic [N_OUT-1:0] en_v, sq_v;
  logic [S_W-1:0]   rate_sel, sync_sel, mod_sel;

  ocd_cfg_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_a(ctl_a_wr), .data_a(ctl_a_data),
    .wr_b(ctl_b_wr), .data_b(ctl_b_data),
    .cfg(cfg), .restart(restart)
  );

  ocd_prescaler #(.K_W(K_W)) u_pre (
    .clk(clk), .rst(rst), .restart(restart),
    .k_raw(cfg.k), .k_eff(k_eff), .tick(tick)
  );

  ocd_postdiv #(.S_W(S_W), .N_OUT(N_OUT)) u_post (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick),
    .sel(cfg.sel), .en(en_v), .sq(sq_v)
  );

  assign rate_sel = cfg.sel[IDX_RATE];
  assign sync_sel = cfg.sel[IDX_SYNC];
  assign mod_sel  = cfg.sel[IDX_MOD];

  assign rate_en  = en_v[IDX_RATE];
  assign sync_en  = en_v[IDX_SYNC];
  assign mod_en   = en_v[IDX_MOD];
  assign rate_clk = sq_v[IDX_RATE];
  assign sync_clk = sq_v[IDX_SYNC];
  assign mod_clk  = sq_v[IDX_MOD];
endmodule

// File: rtl/osc_clk_divider_chk.sv
module osc_clk_divider_chk (
  input logic       clk,
  input logic       rst,
  input logic       restart,
  input logic       tick,
  input logic [5:0] k_eff,
  input logic [2:0] rate_sel,
  input logic [2:0] sync_sel,
  input logic [2:0] mod_sel,
  input logic       rate_en,
  input logic       sync_en,
  input logic       mod_en,
  input logic       rate_clk,
  input logic       sync_clk,
  input logic       mod_clk
);
  logic [6:0] since_tick;

  always_ff @(posedge clk) begin
    if (rst || restart || tick) since_tick <= '0;
    else if (since_tick != 7'h7f) since_tick <= since_tick + 7'd1;
  end

  // R1: square waves are low right after reset
  a_r1_sq_reset: assert property (@(posedge clk)
    rst |=> (!rate_clk && !sync_clk && !mod_clk));

  // R3: prescaler never stalls, ticks at least every 63 cycles
  a_r3_no_stall: assert property (@(posedge clk) disable iff (rst)
    since_tick < 7'd64);

  // R4: after a restart the prescaler ticks at once only when K is 1
  a_r4_restart_phase: assert property (@(posedge clk) disable iff (rst)
    restart |=> (tick == (k_eff == 6'd1)));

  // R6: pulses are one cycle wide when the prescale ratio exceeds 1
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (rate_en && k_eff != 6'd1 && !restart) |=> !rate_en);

  // R7: faster strobes coincide with every pulse of a slower one
  a_r7_sync_aligned: assert property (@(posedge clk) disable iff (rst)
    (rate_en && sync_sel <= rate_sel) |-> sync_en);
  a_r7_mod_aligned: assert property (@(posedge clk) disable iff (rst)
    (rate_en && mod_sel <= rate_sel) |-> mod_en);

  // R8: square wave flips after a pulse and holds otherwise
  a_r8_rate_flip: assert property (@(posedge clk) disable iff (rst)
    rate_en |=> (rate_clk != $past(rate_clk)));
  a_r8_sync_hold: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> $stable(sync_clk));
endmodule

bind osc_clk_divider osc_clk_divider_chk u_chk (
  .clk(clk), .rst(rst), .restart(restart), .tick(tick), .k_eff(k_eff),
  .rate_sel(rate_sel), .sync_sel(sync_sel), .mod_sel(mod_sel),
  .rate_en(rate_en), .sync_en(sync_en), .mod_en(mod_en),
  .rate_clk(rate_clk), .sync_clk(sync_clk), .mod_clk(mod_clk)
);

// File: tb/osc_clk_divider_bench.sv
module osc_clk_divider_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       a_wr = 1'b0, b_wr = 1'b0;
  logic [7:0] a_d = '0, b_d = '0;
  logic       rate_en, sync_en, mod_en, rate_clk, sync_clk, mod_clk;

  int n_chk = 0;
  int n_fail = 0;

  osc_clk_divider u_osc_clk_divider (
    .clk(clk), .rst(rst),
    .ctl_a_wr(a_wr), .ctl_a_data(a_d),
    .ctl_b_wr(b_wr), .ctl_b_data(b_d),
    .rate_en(rate_en), .sync_en(sync_en), .mod_en(mod_en),
    .rate_clk(rate_clk), .sync_clk(sync_clk), .mod_clk(mod_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_words(input bit wa, input logic [7:0] va,
                             input bit wb, input logic [7:0] vb);
    @(negedge clk);
    a_wr = wa; a_d = va; b_wr = wb; b_d = vb;
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  // R2 encoding: A = {0, mod[2:0], sync[2:0], rate[2]}, B = {rate[1:0], K[5:0]}
  function automatic logic [7:0] enc_a(int sr, int ss, int sm);
    return {1'b0, 3'(sm), 3'(ss), 1'(sr >> 2)};
  endfunction
  function automatic logic [7:0] enc_b(int k, int sr);
    return {2'(sr), 6'(k)};
  endfunction

  // Called at the negedge just after the restarting write edge (cycle 0)
  task automatic observe(input int k, input int sr, input int ss, input int sm,
                         input string tag);
    int ke, s[3], p[3], first[3], second[3], maxn, viol, tbad, wbad;
    logic [2:0] en, pen, sq, psq;
    ke = (k == 0) ? 1 : k;
    s[0] = sr; s[1] = ss; s[2] = sm;
    maxn = 0;
    for (int i = 0; i < 3; i++) begin
      p[i] = ke << s[i];
      first[i] = -1; second[i] = -1;
      if (2 * p[i] + 2 > maxn) maxn = 2 * p[i] + 2;
    end
    viol = 0; tbad = 0; wbad = 0; pen = '0; psq = '0;
    for (int n = 0; n < maxn; n++) begin
      en = {mod_en, sync_en, rate_en};
      sq = {mod_clk, sync_clk, rate_clk};
      for (int i = 0; i < 3; i++) begin
        if (en[i]) begin
          if (first[i] < 0) first[i] = n;
          else if (second[i] < 0) second[i] = n;
          if (pen[i] && p[i] > 1 && n > 0) wbad++;
        end
        for (int j = 0; j < 3; j++)
          if (en[j] && s[i] <= s[j] && !en[i]) viol++;
        if (n > 0 && sq[i] != (psq[i] ^ pen[i])) tbad++;
      end
      pen = en; psq = sq;
      @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      chk(first[i] == p[i] - 1, {"R4 first pulse ", tag}, first[i], p[i] - 1);
      chk(second[i] - first[i] == p[i], {"R5 interval ", tag}, second[i] - first[i], p[i]);
    end
    chk(wbad == 0, {"R6 pulse width ", tag}, wbad, 0);
    chk(viol == 0, {"R7 alignment ", tag}, viol, 0);
    chk(tbad == 0, {"R8 square wave ", tag}, tbad, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({rate_clk, sync_clk, mod_clk} == 3'b000, "R1 square waves cleared",
        {rate_clk, sync_clk, mod_clk}, 0);
    chk({rate_en, sync_en, mod_en} == 3'b111, "R1 default strobes",
        {rate_en, sync_en, mod_en}, 7);
  endtask

  task automatic t_case(input int k, input int sr, input int ss, input int sm,
                        input string tag);
    write_words(1'b1, enc_a(sr, ss, sm), 1'b1, enc_b(k, sr));
    observe(k, sr, ss, sm, tag);
  endtask

  task automatic t_zero_k();
    write_words(1'b1, enc_a(4, 0, 1), 1'b1, enc_b(0, 4));
    observe(0, 4, 0, 1, "R3 K=0");
  endtask

  task automatic t_split_write();
    write_words(1'b1, enc_a(5, 1, 2), 1'b0, 8'hff);
    write_words(1'b0, 8'h00, 1'b1, enc_b(3, 5));
    observe(3, 5, 1, 2, "R9 separate writes");
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_case(1, 0, 0, 0, "R2 K1 S0");
    t_case(5, 6, 2, 3, "R2 K5");
    t_case(7, 3, 7, 1, "R2 K7");
    t_case(2, 5, 1, 2, "R2 K2");
    t_case(63, 7, 3, 4, "R2 K63");
    t_zero_k();
    t_split_write();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule